// File: doc/BRIEF.md
# Fixed-Point Step Executor

This block decodes and executes one 32-bit instruction word per clock for a small fixed-point subset: add immediate, load word with zero extension, store word, store word with base update, and register OR. It owns a general register file of 32 entries of 64 bits and drives a word-wide memory port whose read data returns in the same cycle. Address, write data and write enable are combinational from the instruction and the register contents; register updates take effect at the next rising clock edge.

The caller presents an instruction with `step` high for exactly the cycles it wants executed. Any encoding outside the subset raises `illegal` for that cycle and leaves registers and memory untouched. A combinational probe port reads any register so that the owning pipeline, or a test, can observe architectural state.

Instruction bits are numbered here by their position in the word, bit 31 being the most significant. The base field doubles as a literal zero for add immediate, load and plain store, while the update store always reads and rewrites the addressed register, including entry 0.

Top module: `fxu_core`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero.
- R2: The primary opcode is instr[31:26]: 100000 load, 100100 store, 100101 store with update, 001110 add immediate; OR is primary 011111 with instr[10:1] equal to 0110111100; fields are A = instr[25:21], B = instr[20:16], C = instr[15:11], displacement = instr[15:0]. A recognised encoding with `step` high keeps `illegal` low.
- R3: Add immediate writes register A with (B==0 ? 0 : reg[B]) plus the sign-extended displacement.
- R4: Load drives `mem_addr` with (B==0 ? 0 : reg[B]) plus the sign-extended displacement, keeps `mem_we` low, and writes register A with 32 zero bits above `mem_rdata`.
- R5: Store drives the same address as R4, `mem_wdata` = low 32 bits of register A, `mem_we` high, and changes no register.
- R6: Store with update uses reg[B] as base even when B is 0, stores the low word of register A to reg[B] plus the sign-extended displacement, and writes that address back into register B.
- R7: OR writes reg[A] | reg[C] into register B; instr[0] has no effect on the result or on any other state.
- R8: Any other encoding with `step` high, including primary 011111 with a different instr[10:1], sets `illegal` and changes neither registers nor memory (`mem_we` low).
- R9: With `step` low, `illegal` and `mem_we` stay low and no register changes.
- R10: `probe_data` shows register `probe_sel` combinationally; a register write is visible there after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Execute `instr` this cycle |
| instr | input | 32 | Instruction word |
| mem_rdata | input | 32 | Memory word at `mem_addr`, same cycle |
| probe_sel | input | 5 | Register index to observe |
| mem_addr | output | 64 | Effective byte address |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe |
| illegal | output | 1 | Unrecognised encoding this cycle |
| probe_data | output | 64 | Contents of register `probe_sel` |

## Verification
Every cycle the assertions check that an illegal or idle cycle writes nothing, that a load result carries zeros in its upper half and the memory word below, that an update store writes its own address back to the base register, that a plain store leaves the registers alone, that each register write lands and that reset leaves all registers zero. Only the bench scenarios can show the arithmetic itself: the literal-zero base against entry 0, sign extension of negative and boundary displacements, the update store through entry 0, and that the OR record bit changes nothing, all compared with a reference model of every register after each instruction.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

    localparam int XLEN = 64;
    localparam int WORD = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int ILEN = 32;
    localparam int DLEN = 16;

    localparam logic [5:0] PO_LOAD  = 6'b100000;
    localparam logic [5:0] PO_STORE = 6'b100100;
    localparam logic [5:0] PO_STUPD = 6'b100101;
    localparam logic [5:0] PO_ADDI  = 6'b001110;
    localparam logic [5:0] PO_EXT   = 6'b011111;
    localparam logic [9:0] XO_OR    = 10'b0110111100;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_STORE,
        OP_STUPD,
        OP_ADDI,
        OP_OR,
        OP_BAD
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [RIDX-1:0]  fa;
        logic [RIDX-1:0]  fb;
        logic [RIDX-1:0]  fc;
        logic [DLEN-1:0]  disp;
    } dec_t;

    function automatic logic [XLEN-1:0] sext_disp(input logic [DLEN-1:0] v);
        return {{(XLEN-DLEN){v[DLEN-1]}}, v};
    endfunction

endpackage

// File: rtl/fxu_decode.sv
module fxu_decode
    import fxu_pkg::*;
(
    input  logic            step,
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    logic [5:0] primary;
    logic [9:0] xop;
    logic       unused_rc;

    assign primary   = instr[31:26];
    assign xop       = instr[10:1];
    assign unused_rc = instr[0];

    always_comb begin
        dec.fa   = instr[25:21];
        dec.fb   = instr[20:16];
        dec.fc   = instr[15:11];
        dec.disp = instr[15:0];
        if (!step) begin
            dec.op = OP_IDLE;
        end else begin
            unique case (primary)
                PO_LOAD:  dec.op = OP_LOAD;
                PO_STORE: dec.op = OP_STORE;
                PO_STUPD: dec.op = OP_STUPD;
                PO_ADDI:  dec.op = OP_ADDI;
                PO_EXT:   dec.op = (xop == XO_OR) ? OP_OR : OP_BAD;
                default:  dec.op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/fxu_regfile.sv
module fxu_regfile #(
    parameter int XW  = 64,
    parameter int NR  = 32,
    parameter int NRD = 4,
    localparam int AW = $clog2(NR)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [XW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][XW-1:0]   rdata
);
    logic [NR-1:0][XW-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs[raddr[g]];
    end

    // R10: a write is held by the addressed entry after its edge
    assert_rf_commit_R10: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));

    // R1: the cycle after reset drops, every entry is zero
    assert_rst_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> regs == '0);
endmodule

// File: rtl/fxu_exec.sv
module fxu_exec
    import fxu_pkg::*;
#(
    parameter int XW = 64,
    parameter int WW = 32,
    localparam int AW = $clog2(NREG)
) (
    input  dec_t            dec,
    input  logic [XW-1:0]   val_a,
    input  logic [XW-1:0]   val_b,
    input  logic [XW-1:0]   val_c,
    input  logic [WW-1:0]   mem_rdata,
    output logic [XW-1:0]   mem_addr,
    output logic [WW-1:0]   mem_wdata,
    output logic            mem_we,
    output logic            rf_we,
    output logic [AW-1:0]   rf_waddr,
    output logic [XW-1:0]   rf_wdata,
    output logic            illegal
);
    logic [XW-1:0] disp_x;
    logic [XW-1:0] base_lit;
    logic [XW-1:0] ea_lit;
    logic [XW-1:0] ea_upd;

    assign disp_x   = {{(XW-DLEN){dec.disp[DLEN-1]}}, dec.disp};
    assign base_lit = (dec.fb == '0) ? '0 : val_b;
    assign ea_lit   = base_lit + disp_x;
    assign ea_upd   = val_b + disp_x;

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        rf_waddr  = '0;
        rf_wdata  = '0;
        illegal   = 1'b0;
        unique case (dec.op)
            OP_LOAD: begin
                mem_addr = ea_lit;
                rf_we    = 1'b1;
                rf_waddr = dec.fa;
                rf_wdata = {{(XW-WW){1'b0}}, mem_rdata};
            end
            OP_STORE: begin
                mem_addr  = ea_lit;
                mem_wdata = val_a[WW-1:0];
                mem_we    = 1'b1;
            end
            OP_STUPD: begin
                mem_addr  = ea_upd;
                mem_wdata = val_a[WW-1:0];
                mem_we    = 1'b1;
                rf_we     = 1'b1;
                rf_waddr  = dec.fb;
                rf_wdata  = ea_upd;
            end
            OP_ADDI: begin
                rf_we    = 1'b1;
                rf_waddr = dec.fa;
                rf_wdata = ea_lit;
            end
            OP_OR: begin
                rf_we    = 1'b1;
                rf_waddr = dec.fb;
                rf_wdata = val_a | val_c;
            end
            OP_BAD: begin
                illegal = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/fxu_core.sv
module fxu_core
    import fxu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [31:0]     instr,
    input  logic [31:0]     mem_rdata,
    input  logic [4:0]      probe_sel,
    output logic [63:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    output logic            mem_we,
    output logic            illegal,
    output logic [63:0]     probe_data
);
    localparam int NPORT = 4;

    dec_t                         dec;
    logic                         rf_we;
    logic [RIDX-1:0]              rf_waddr;
    logic [XLEN-1:0]              rf_wdata;
    logic [NPORT-1:0][RIDX-1:0]   rd_idx;
    logic [NPORT-1:0][XLEN-1:0]   rd_val;

    fxu_decode u_dec (
        .step (step),
        .instr(instr),
        .dec  (dec)
    );

    assign rd_idx[0] = dec.fa;
    assign rd_idx[1] = dec.fb;
    assign rd_idx[2] = dec.fc;
    assign rd_idx[3] = probe_sel;

    fxu_regfile #(.XW(XLEN), .NR(NREG), .NRD(NPORT)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (rf_we),
        .waddr(rf_waddr),
        .wdata(rf_wdata),
        .raddr(rd_idx),
        .rdata(rd_val)
    );

    fxu_exec #(.XW(XLEN), .WW(WORD)) u_ex (
        .dec      (dec),
        .val_a    (rd_val[0]),
        .val_b    (rd_val[1]),
        .val_c    (rd_val[2]),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .illegal  (illegal)
    );

    assign probe_data = rd_val[3];

    assert_bad_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !mem_we && !rf_we);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !step |-> !illegal && !mem_we && !rf_we);

    assert_load_zext_R4: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_LOAD) |-> rf_we && !mem_we &&
            rf_wdata[63:32] == '0 && rf_wdata[31:0] == mem_rdata);

    assert_upd_wb_R6: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_STUPD) |-> mem_we && rf_we &&
            rf_waddr == instr[20:16] && rf_wdata == mem_addr);

    assert_store_noreg_R5: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_STORE) |-> mem_we && !rf_we);
endmodule

// File: tb/sim_fxu_core.sv
module sim_fxu_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [31:0] instr;
    logic [31:0] mem_rdata;
    logic [4:0]  probe_sel;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        illegal;
    logic [63:0] probe_data;

    always #2 clk = ~clk;

    logic [31:0] bmem [256];
    logic [63:0] shadow [32];
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    assign mem_rdata = bmem[mem_addr[9:2]];

    fxu_core u0 (
        .clk(clk), .rst(rst), .step(step), .instr(instr),
        .mem_rdata(mem_rdata), .probe_sel(probe_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .illegal(illegal), .probe_data(probe_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx(input logic [15:0] v);
        return {{48{v[15]}}, v};
    endfunction

    function automatic logic [31:0] dform(input logic [5:0] po, input logic [4:0] a,
                                          input logic [4:0] b, input logic [15:0] d);
        return {po, a, b, d};
    endfunction

    function automatic logic [31:0] orx(input logic [4:0] s, input logic [4:0] a,
                                        input logic [4:0] b, input logic rc);
        return {6'b011111, s, a, b, 10'b0110111100, rc};
    endfunction

    function automatic bit legal(input logic [31:0] w);
        case (w[31:26])
            6'b100000, 6'b100100, 6'b100101, 6'b001110: return 1'b1;
            6'b011111: return w[10:1] == 10'b0110111100;
            default: return 1'b0;
        endcase
    endfunction

    // R10: full register sweep through the probe port, step held low (R9)
    task automatic sweep(input string req);
        step = 1'b0;
        for (int i = 0; i < 32; i++) begin
            probe_sel = 5'(i);
            #1;
            chk(req, $sformatf("probe r%0d", i), probe_data, shadow[i]);
        end
        chk("R9", "idle illegal", {63'd0, illegal}, 64'd0);
        chk("R9", "idle mem_we", {63'd0, mem_we}, 64'd0);
    endtask

    task automatic run(input logic [31:0] w, input string req);
        logic [5:0]  po;
        logic [4:0]  fa, fb, fc;
        logic [63:0] base, ea, rval;
        logic [31:0] wval;
        bit          ill, mwe, rwe, chk_addr;
        logic [4:0]  ridx;
        po = w[31:26]; fa = w[25:21]; fb = w[20:16]; fc = w[15:11];
        base = (fb == 5'd0) ? 64'd0 : shadow[fb];
        ill = 1'b0; mwe = 1'b0; rwe = 1'b0; chk_addr = 1'b0;
        ea = '0; rval = '0; wval = '0; ridx = '0;
        if (!legal(w)) begin
            ill = 1'b1;
        end else begin
            case (po)
                6'b100000: begin
                    ea = base + sx(w[15:0]); chk_addr = 1'b1;
                    rwe = 1'b1; ridx = fa; rval = {32'd0, bmem[ea[9:2]]};
                end
                6'b100100: begin
                    ea = base + sx(w[15:0]); chk_addr = 1'b1;
                    mwe = 1'b1; wval = shadow[fa][31:0];
                end
                6'b100101: begin
                    ea = shadow[fb] + sx(w[15:0]); chk_addr = 1'b1;
                    mwe = 1'b1; wval = shadow[fa][31:0];
                    rwe = 1'b1; ridx = fb; rval = ea;
                end
                6'b001110: begin
                    rwe = 1'b1; ridx = fa; rval = base + sx(w[15:0]);
                end
                default: begin
                    rwe = 1'b1; ridx = fb; rval = shadow[fa] | shadow[fc];
                end
            endcase
        end
        @(negedge clk);
        instr = w;
        step = 1'b1;
        #1;
        chk(ill ? "R8" : "R2", "illegal", {63'd0, illegal}, {63'd0, ill});
        chk(req, "mem_we", {63'd0, mem_we}, {63'd0, mwe});
        if (chk_addr) chk(req, "mem_addr", mem_addr, ea);
        if (mwe) chk(req, "mem_wdata", {32'd0, mem_wdata}, {32'd0, wval});
        @(posedge clk);
        #1;
        step = 1'b0;
        if (mwe) bmem[ea[9:2]] = wval;
        if (rwe) shadow[ridx] = rval;
        sweep(req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [4:0]  a, b, c;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 256; i++) bmem[i] = $urandom;
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        rst = 1'b1; step = 1'b0; instr = '0; probe_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        sweep("R1");

        // R3: base field 0 is literal zero; negative displacement sign-extends
        run(dform(6'b001110, 5'd3, 5'd0, 16'hFFFF), "R3");
        run(dform(6'b001110, 5'd0, 5'd0, 16'd100), "R3");
        run(dform(6'b001110, 5'd4, 5'd0, 16'd7), "R3");
        run(dform(6'b001110, 5'd5, 5'd3, 16'h7FFF), "R3");
        run(dform(6'b001110, 5'd9, 5'd4, 16'h8000), "R3");
        // R4: load of an all-ones word zero-extends; literal zero base
        bmem[2] = 32'hFFFF_FFFF;
        run(dform(6'b100000, 5'd6, 5'd0, 16'd8), "R4");
        run(dform(6'b100000, 5'd10, 5'd0, 16'd100), "R4");
        // R5: store low word of an all-ones register
        run(dform(6'b100100, 5'd3, 5'd4, 16'hFFFD), "R5");
        run(dform(6'b100000, 5'd11, 5'd0, 16'd4), "R5");
        // R6: update store through entry 0 uses its contents and rewrites it
        run(dform(6'b100101, 5'd4, 5'd0, 16'd16), "R6");
        run(dform(6'b100101, 5'd5, 5'd9, 16'hFFF0), "R6");
        // R7: OR with record bit clear and set gives the same result
        run(orx(5'd4, 5'd8, 5'd6, 1'b0), "R7");
        run(orx(5'd4, 5'd12, 5'd6, 1'b1), "R7");
        run(orx(5'd3, 5'd0, 5'd9, 1'b1), "R7");
        // R8: zero word, near-miss extended opcode, unused primary
        run(32'h0000_0000, "R8");
        run({6'b011111, 5'd1, 5'd2, 5'd3, 10'b0110111101, 1'b0}, "R8");
        run(dform(6'b100001, 5'd1, 5'd2, 16'd4), "R8");

        for (int n = 0; n < 300; n++) begin
            a = 5'($urandom_range(0, 31));
            b = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(0, 31));
            c = 5'($urandom_range(0, 31));
            case ($urandom_range(0, 6))
                0: run(dform(6'b100000, a, b, 16'($urandom)), "R4");
                1: run(dform(6'b100100, a, b, 16'($urandom)), "R5");
                2: run(dform(6'b100101, a, b, 16'($urandom)), "R6");
                3: run(dform(6'b001110, a, b, 16'($urandom)), "R3");
                4: run(orx(a, b, c, 1'($urandom)), "R7");
                5: begin
                    w = {6'b011111, 15'($urandom), 10'($urandom), 1'($urandom)};
                    if (w[10:1] == 10'b0110111100) w[1] = ~w[1];
                    run(w, "R8");
                end
                default: begin
                    w = $urandom;
                    while (legal(w)) w = $urandom;
                    run(w, "R8");
                end
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule